// File: doc/BRIEF.md
# Programmable Audio Frame Sync Generator

This block produces the frame-sync waveform for a serial audio port that runs as the master of its link in I2S, left-justified or PCM format. It counts bit-clock ticks, which arrive as a one-cycle enable strobe on the system clock. Each frame is asserted for a programmed number of ticks and then deasserted for the rest of a programmed total period, which covers both phases. The pattern then repeats. The assert-width field holds the asserted length minus one. A one-clock start-of-frame pulse marks each tick on which a frame begins.

The period and width are sampled only at a frame boundary, so a frame in progress always finishes with the settings it started with. A zero period, or a period smaller than the assert-width field, is illegal. The error flag reports such a setting on the clock after it appears. The block then starts no new frame: it finishes any frame in progress and then holds the frame line deasserted until a legal setting is present. I2S uses an active-low frame. The two other formats use an active-high frame. With the format select at "off" the block drives the frame line low and stays idle.

Top module: `frame_sync_gen`

## Requirements
- R1: While running with a legal configuration, the tick on which one frame starts and the tick on which the next frame starts are exactly P ticks apart, where P is the total-period input.
- R2: When the block is enabled in a master format with a legal configuration, the first frame starts on the first tick after that. The frame line is at its asserted level in the clock that follows that tick.
- R3: Each frame is asserted for W+1 ticks, where W is the assert-width input, and deasserted for the remaining P-(W+1) ticks. If W equals P, the frame is asserted for the whole period.
- R4: The internal position advances only on clocks where the bit-clock strobe is high. With a strobe every N clocks, one frame lasts N*P clocks.
- R5: The start-of-frame output is high for exactly one clock. That clock follows each tick on which a frame starts, and the start-of-frame output is low in every other clock.
- R6: The configuration is illegal when P is 0 or P is less than W, comparing both as unsigned numbers. The error flag is high in the clock after any clock in which an illegal configuration is present while the block is enabled in a master format. With an illegal configuration no new frame starts, no start-of-frame pulse occurs, and after the current frame the line stays deasserted.
- R7: Format select 2'b00 means not master. In that case the frame line is 0, and start-of-frame and error are 0. With enable low in a master format, the frame line sits at its deasserted level, and counting restarts from a new frame when enable returns.
- R8: The frame polarity follows the format select. 2'b01 (I2S) is active-low. 2'b10 (left-justified) and 2'b11 (PCM) are active-high.
- R9: After a synchronous active-low reset, with format select 2'b00, the frame line, start-of-frame and error are all 0.
- R10: P and W are taken in only on the tick that starts a frame. A change during a frame does not alter that frame's length or width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_tick | input | 1 | One-clock strobe per bit-clock period |
| enable | input | 1 | Run enable |
| fmt_sel | input | 2 | 00 off, 01 I2S, 10 left-justified, 11 PCM |
| period_cfg | input | PERIOD_W (9) | Total frame period in ticks |
| width_cfg | input | WIDTH_W (25) | Asserted width minus one |
| fsync | output | 1 | Frame-sync line |
| frame_start | output | 1 | Start-of-frame pulse |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The bench builds the block with its default widths: a 9-bit period field and a 25-bit width field. With these widths the legality check can be driven with width values far above any reachable period, such as 600 against 511. The edge cases where W equals P, W equals P plus one, and W is zero are also reachable. Short periods of 4 to 16 ticks keep each frame within a few dozen clocks. A strobe every clock lets lengths be measured directly, and a strobe every third clock exercises tick gating.

// File: rtl/afs_pkg.sv
`timescale 1ns/1ps
// Shared types for the frame sync generator.
package afs_pkg;
    // Format select encoding; FS_OFF means the port is not link master.
    typedef enum logic [1:0] {
        FS_OFF = 2'b00,
        FS_I2S = 2'b01,
        FS_LJ  = 2'b10,
        FS_PCM = 2'b11
    } fs_mode_e;
endpackage

// File: rtl/afs_cfg_check.sv
`timescale 1ns/1ps
// Configuration legality check.
// Flags a zero period or a period below the width field (unsigned).
// Assumes: go is high only in a master format with enable set.
module afs_cfg_check #(
    parameter int PERIOD_W = 9,
    parameter int WIDTH_W  = 25
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [PERIOD_W-1:0] period_in,
    input  logic [WIDTH_W-1:0]  width_in,
    output logic                legal,
    output logic                err_q
);
    localparam int CMP_W = (WIDTH_W > PERIOD_W) ? WIDTH_W : PERIOD_W;

    logic [CMP_W-1:0] per_x;
    logic [CMP_W-1:0] wid_x;

    // Widen both fields to a common width for the comparison.
    always_comb begin
        per_x = CMP_W'(period_in);
        wid_x = CMP_W'(width_in);
        legal = (per_x != '0) && (per_x >= wid_x);
    end

    // Register the error flag for enabled master operation.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= go && !legal;
    end
endmodule

// File: rtl/afs_counter.sv
`timescale 1ns/1ps
// Frame position counter with boundary-latched configuration.
// Counts ticks 0..P-1 and reports the asserted phase (position <= W).
// Loads new settings only on a frame start; stops at a boundary if illegal.
// Assumes: legal comes from afs_cfg_check on the same period/width inputs.
module afs_counter #(
    parameter int PERIOD_W = 9,
    parameter int WIDTH_W  = 25
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                tick,
    input  logic                legal,
    input  logic [PERIOD_W-1:0] period_in,
    input  logic [WIDTH_W-1:0]  width_in,
    output logic                phase_on,
    output logic                sof
);
    localparam int CMP_W = (WIDTH_W > PERIOD_W) ? WIDTH_W : PERIOD_W;

    logic                run;
    logic [PERIOD_W-1:0] cnt;
    logic [PERIOD_W-1:0] sh_per;
    logic [WIDTH_W-1:0]  sh_wid;
    logic                at_end;

    // Detect the last tick of the running frame.
    always_comb begin
        at_end   = (cnt == sh_per - PERIOD_W'(1));
        phase_on = run && (CMP_W'(cnt) <= CMP_W'(sh_wid));
    end

    // Advance position, restart frames and latch settings at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            cnt    <= '0;
            sh_per <= '0;
            sh_wid <= '0;
            sof    <= 1'b0;
        end else begin
            sof <= 1'b0;
            if (!go) begin
                run <= 1'b0;
                cnt <= '0;
            end else if (tick) begin
                if (!run || at_end) begin
                    cnt <= '0;
                    if (legal) begin
                        run    <= 1'b1;
                        sh_per <= period_in;
                        sh_wid <= width_in;
                        sof    <= 1'b1;
                    end else begin
                        run <= 1'b0;
                    end
                end else begin
                    cnt <= cnt + PERIOD_W'(1);
                end
            end
        end
    end

    // Position does not move without a tick while enabled.
    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !tick) |=> $stable(cnt));

    // Position never reaches the latched period.
    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < sh_per));

    // Latched settings change only on a frame start.
    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (go && run && !(tick && at_end)) |=> ($stable(sh_per) && $stable(sh_wid)));

    // Start pulse coincides with position zero of a running frame.
    assert_sof_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (run && cnt == '0));
endmodule

// File: rtl/afs_polarity.sv
`timescale 1ns/1ps
// Output level stage: maps the asserted phase onto the format's polarity.
// Assumes: phase_on is low whenever the counter is idle.
module afs_polarity
    import afs_pkg::*;
(
    input  fs_mode_e fmt,
    input  logic     phase_on,
    output logic     fsync
);
    // Select the line level from format and phase.
    always_comb begin
        unique case (fmt)
            FS_OFF:  fsync = 1'b0;
            FS_I2S:  fsync = !phase_on;
            default: fsync = phase_on;
        endcase
    end
endmodule

// File: rtl/frame_sync_gen.sv
`timescale 1ns/1ps
// Frame sync generator top: legality check, frame counter, polarity stage.
// Assumes: bclk_tick is a single-clock strobe from the bit clock divider.
module frame_sync_gen
    import afs_pkg::*;
#(
    parameter int PERIOD_W = 9,
    parameter int WIDTH_W  = 25
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_tick,
    input  logic                enable,
    input  logic [1:0]          fmt_sel,
    input  logic [PERIOD_W-1:0] period_cfg,
    input  logic [WIDTH_W-1:0]  width_cfg,
    output logic                fsync,
    output logic                frame_start,
    output logic                cfg_err
);
    fs_mode_e fmt;
    logic     go;
    logic     legal;
    logic     phase_on;

    // Decode the format and the run condition.
    always_comb begin
        fmt = fs_mode_e'(fmt_sel);
        go  = enable && (fmt != FS_OFF);
    end

    afs_cfg_check #(.PERIOD_W(PERIOD_W), .WIDTH_W(WIDTH_W)) chk_i (
        .clk(clk), .rst_n(rst_n), .go(go),
        .period_in(period_cfg), .width_in(width_cfg),
        .legal(legal), .err_q(cfg_err)
    );

    afs_counter #(.PERIOD_W(PERIOD_W), .WIDTH_W(WIDTH_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .go(go), .tick(bclk_tick), .legal(legal),
        .period_in(period_cfg), .width_in(width_cfg),
        .phase_on(phase_on), .sof(frame_start)
    );

    afs_polarity pol_i (.fmt(fmt), .phase_on(phase_on), .fsync(fsync));

    // A frame start shows the format's asserted level.
    assert_sof_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && fmt != FS_OFF) |-> (fsync == (fmt != FS_I2S)));

    // An error clock never carries a frame start.
    assert_err_no_sof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !frame_start);
endmodule

// File: tb/frame_sync_gen_tb_top.sv
`timescale 1ns/1ps
module frame_sync_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_tick = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [8:0]  period_cfg = '0;
    logic [24:0] width_cfg = '0;
    logic        fsync, frame_start, cfg_err;

    int tests = 0;
    int fails = 0;
    int div = 1;
    int phase = 0;
    int cyc = 0;
    int sof_seen = 0;
    int last_sof = 0;
    bit done = 0;

    // model state
    int  m_run = 0, m_cnt = 0, m_p = 0, m_w = 0;
    bit  m_sof = 0, m_err = 0;

    always #10 clk = ~clk;

    frame_sync_gen dut_i (
        .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .enable(enable),
        .fmt_sel(fmt_sel), .period_cfg(period_cfg), .width_cfg(width_cfg),
        .fsync(fsync), .frame_start(frame_start), .cfg_err(cfg_err)
    );

    // tick generator: one strobe every div clocks
    always @(negedge clk) begin
        phase = (phase + 1) % div;
        bclk_tick <= (phase == 0);
    end

    // behavioural reference
    always @(posedge clk) begin
        int p, w;
        bit master, ok;
        p = int'(period_cfg);
        w = int'(width_cfg);
        master = enable && (fmt_sel != 2'b00);
        ok = (p != 0) && (p >= w);
        cyc++;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_p = 0; m_w = 0; m_sof = 0; m_err = 0;
        end else begin
            m_sof = 0;
            m_err = master && !ok;
            if (!master) begin
                m_run = 0; m_cnt = 0;
            end else if (bclk_tick) begin
                if (m_run == 0 || m_cnt == m_p - 1) begin
                    m_cnt = 0;
                    if (ok) begin m_run = 1; m_p = p; m_w = w; m_sof = 1; end
                    else m_run = 0;
                end else m_cnt++;
            end
        end
    end

    function automatic bit exp_fs();
        bit on;
        on = (m_run != 0) && (m_cnt <= m_w);
        if (fmt_sel == 2'b00) return 1'b0;
        if (fmt_sel == 2'b01) return !on;
        return on;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference, away from the edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            check("R3 fsync vs model", fsync, exp_fs());
            check("R5 frame_start vs model", frame_start, m_sof);
            check("R6 cfg_err vs model", cfg_err, m_err);
        end
        if (frame_start) begin sof_seen++; last_sof = cyc; end
    end

    task automatic sample();
        @(posedge clk); #6;
    endtask

    task automatic setup(input int d, input logic [1:0] f, input int p, input int w);
        @(negedge clk);
        div = d; fmt_sel = f; period_cfg = 9'(p); width_cfg = 25'(w); enable = 1'b1;
    endtask

    task automatic stop();
        @(negedge clk); enable = 1'b0; fmt_sel = 2'b00;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_sof();
        int n = 0;
        do begin sample(); n++; end while (!frame_start && n < 3000);
    endtask

    // measure width (asserted clocks) and period (clocks to next start)
    task automatic measure(input bit act, output int wid, output int per);
        bit off = 0;
        wait_sof();
        wid = 0; per = 0;
        do begin
            if (fsync == act && !off) wid++; else off = 1;
            per++;
            sample();
        end while (!frame_start && per < 3000);
    endtask

    initial begin
        int wd, pr, s0, c0;
        repeat (3) @(negedge clk);
        sample();
        check("R9 fsync in reset", fsync, 0);
        check("R9 frame_start in reset", frame_start, 0);
        @(negedge clk); rst_n = 1'b1;
        sample();
        check("R9 fsync after reset", fsync, 0);
        check("R9 cfg_err after reset", cfg_err, 0);

        // start timing: enable at negedge, strobe every clock
        setup(1, 2'b10, 8, 2);
        sample();
        check("R2 first frame starts on first tick", frame_start, 1);
        check("R2 asserted at start", fsync, 1);
        measure(1'b1, wd, pr);
        check("R3 LJ width W+1", wd, 3);
        check("R1 LJ period", pr, 8);
        stop();

        setup(1, 2'b01, 16, 7);
        measure(1'b0, wd, pr);
        check("R8 I2S active-low width", wd, 8);
        check("R1 I2S period", pr, 16);
        @(negedge clk); enable = 1'b0;
        sample(); sample();
        check("R7 I2S disabled idles high", fsync, 1);
        stop();

        setup(1, 2'b11, 5, 0);
        measure(1'b1, wd, pr);
        check("R8 PCM active-high width 1", wd, 1);
        check("R1 PCM period", pr, 5);
        stop();

        // W equals P: asserted across the whole period
        setup(1, 2'b10, 4, 4);
        measure(1'b1, wd, pr);
        check("R3 W=P full width", wd, 4);
        check("R1 W=P period", pr, 4);
        check("R6 W=P legal", cfg_err, 0);
        stop();

        // tick gating
        setup(3, 2'b10, 6, 1);
        measure(1'b1, wd, pr);
        check("R4 width in clocks", wd, 6);
        check("R4 period in clocks", pr, 18);
        stop();
        div = 1;

        // illegal settings
        setup(1, 2'b10, 0, 0);
        s0 = sof_seen;
        repeat (20) sample();
        check("R6 zero period err", cfg_err, 1);
        check("R6 zero period no start", sof_seen - s0, 0);
        check("R6 zero period deasserted", fsync, 0);
        @(negedge clk); period_cfg = 9'd3; width_cfg = 25'd4;
        repeat (10) sample();
        check("R6 P<W err", cfg_err, 1);
        @(negedge clk); period_cfg = 9'd511; width_cfg = 25'd600;
        repeat (10) sample();
        check("R6 wide W err", cfg_err, 1);
        check("R6 no start while illegal", sof_seen - s0, 0);
        @(negedge clk); period_cfg = 9'd6; width_cfg = 25'd1;
        measure(1'b1, wd, pr);
        check("R6 recovers on legal", pr, 6);
        // turn illegal mid-run
        @(negedge clk); period_cfg = 9'd0;
        s0 = sof_seen;
        repeat (20) sample();
        check("R6 stops after frame", sof_seen - s0, 0);
        check("R6 deasserted after stop", fsync, 0);
        stop();

        // boundary latching
        setup(1, 2'b10, 10, 1);
        wait_sof();
        c0 = last_sof;
        repeat (3) @(negedge clk);
        period_cfg = 9'd6; width_cfg = 25'd3;
        wait_sof();
        check("R10 frame in progress keeps period", last_sof - c0, 10);
        measure(1'b1, wd, pr);
        check("R10 new width applied", wd, 4);
        check("R10 new period applied", pr, 6);
        stop();

        // not master
        @(negedge clk); enable = 1'b1; fmt_sel = 2'b00; period_cfg = 9'd0;
        s0 = sof_seen;
        repeat (15) sample();
        check("R7 off fsync", fsync, 0);
        check("R7 off no start", sof_seen - s0, 0);
        check("R7 off no err", cfg_err, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule